// File: doc/BRIEF.md
# Two-Level Translation Table Walker

The walker turns a 32-bit virtual address into a physical address by reading one or two word descriptors from a translation table held in memory. A request gives the virtual address and the table base. The walker accepts it with a valid/ready handshake and reads the first-level descriptor. That descriptor is either a fault, a 1 MB section, or a pointer to a second-level table, which may be coarse or fine. When it points to a table, the walker reads a second descriptor from that table. The second descriptor is a fault or a large, small or tiny page.

The result comes back in a single-cycle `done` pulse. It carries the physical address, the domain number, the 2-bit access-permission value and the cacheable and bufferable attributes. On a fault it instead carries a fault flag and the level that failed. The memory port has a request channel with valid/ready and a response channel with valid only. At most one read is outstanding, and the memory may take any number of cycles to answer. Permission checking, domain checking and translation caching belong to other blocks.

Top module: `ptw_walker`

## Requirements
- R1: The first read goes to the word address {tbl_base[31:14], va[31:20], 2'b00}. `mem_req_addr[1:0]` is always 0.
- R2: A first-level descriptor whose bits [1:0] are 00 ends the walk with fault=1 and fault_level=0 (first level). Domain is 0 and no second read is made.
- R3: When first-level bits [1:0] are 10 (section), the walk ends after one read. The outputs are pa={desc[31:20], va[19:0]}, ap=desc[11:10], domain=desc[8:5], cacheable=desc[3] and bufferable=desc[2].
- R4: First-level type 01 (coarse) reads its second descriptor at {desc[31:10], va[19:12], 2'b00}. Type 11 (fine) reads at {desc[31:12], va[19:10], 2'b00}. In both cases the domain comes from first-level bits [8:5].
- R5: A second-level descriptor with bits [1:0]=00 ends the walk with fault=1 and fault_level=1 (second level). The domain is still reported.
- R6: Second-level type 01 is a large page with pa={desc[31:16], va[15:0]}. Its ap is the subpage field desc[2k+5:2k+4], where k=va[15:14]. Cacheable is bit 3 and bufferable is bit 2.
- R7: Second-level type 10 is a small page with pa={desc[31:12], va[11:0]}. Its ap is the subpage field selected by k=va[11:10].
- R8: Second-level type 11 in a fine table is a tiny page with pa={desc[31:10], va[9:0]} and ap=desc[5:4]. In a coarse table the same type is a second-level fault.
- R9: A fine table decodes types 01 and 10 as large and small pages, exactly as a coarse table does.
- R10: `req_ready` is high only while idle, and no memory read is issued while idle. `done` lasts exactly one cycle. On a fault, pa, ap, cacheable and bufferable are all 0.
- R11: A memory request is held with a stable address until it is accepted. Any request stall and any response latency give the same result.
- R12: Reset returns the walker to idle and discards an in-flight walk without ever raising `done` for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, request accepted |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | First-level table base (bits [31:14] used) |
| mem_req_valid | output | 1 | Memory read request valid |
| mem_req_ready | input | 1 | Memory accepts read request |
| mem_req_addr | output | 32 | Word address of descriptor |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor word |
| done | output | 1 | One-cycle result strobe |
| fault | output | 1 | Walk ended in a fault |
| fault_level | output | 1 | 0 = first level, 1 = second level |
| pa | output | 32 | Physical address |
| domain | output | 4 | Domain number |
| ap | output | 2 | Access permission field |
| cacheable | output | 1 | Cacheable attribute |
| bufferable | output | 1 | Bufferable attribute |

## Verification
The bench targets the split between table geometries. If the coarse and fine index widths were swapped, the second read address would be wrong by whole index fields. If a type-11 entry in a coarse table were decoded as a tiny page, a fault would be hidden. Each subpage selector is exercised with virtual addresses that pick a different field, so using the wrong address bits returns a visibly wrong permission value. The bench also resets the walker while a read is waiting on a slow memory: a design that failed to drop the walk would raise `done` afterwards or fail to become ready.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int AW        = 32;
    localparam int DOM_W     = 4;
    localparam int AP_W      = 2;
    localparam int SECT_SH   = 20;  // 1 MB section offset width
    localparam int LARGE_SH  = 16;  // 64 KB page offset width
    localparam int SMALL_SH  = 12;  // 4 KB page offset width
    localparam int TINY_SH   = 10;  // 1 KB page offset width
    localparam int BASE_SH   = 14;  // first-level table alignment
    localparam int COARSE_SH = 10;  // coarse table alignment
    localparam int FINE_SH   = 12;  // fine table alignment
    localparam int SUBPAGES  = 4;
    localparam int SUBAP_LSB = 4;
    localparam int DOM_LSB   = 5;
    localparam int SAP_LSB   = 10;
    localparam int C_BIT     = 3;
    localparam int B_BIT     = 2;

    typedef enum logic [1:0] {
        L1_INV    = 2'b00,
        L1_COARSE = 2'b01,
        L1_SECT   = 2'b10,
        L1_FINE   = 2'b11
    } l1_kind_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT
    } walk_st_e;

    typedef struct packed {
        walk_st_e          st;
        logic [AW-1:0]     va;
        logic [AW-1:0]     maddr;
        logic              fine;
        logic [DOM_W-1:0]  dom;
        logic              done;
        logic              fault;
        logic              flvl;
        logic [AW-1:0]     pa;
        logic [AP_W-1:0]   ap;
        logic              cch;
        logic              bfr;
    } walk_s;
endpackage

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
    import ptw_pkg::*;
(
    input  logic [AW-1:0]    desc,
    input  logic [AW-1:0]    va,
    output l1_kind_e         kind,
    output logic [AW-1:0]    sect_pa,
    output logic [AW-1:0]    l2_addr,
    output logic [DOM_W-1:0] dom,
    output logic [AP_W-1:0]  ap,
    output logic             cch,
    output logic             bfr
);
    always_comb begin
        kind    = l1_kind_e'(desc[1:0]);
        dom     = desc[DOM_LSB +: DOM_W];
        ap      = desc[SAP_LSB +: AP_W];
        cch     = desc[C_BIT];
        bfr     = desc[B_BIT];
        sect_pa = {desc[AW-1:SECT_SH], va[SECT_SH-1:0]};
        if (kind == L1_FINE)
            l2_addr = {desc[AW-1:FINE_SH], va[SECT_SH-1:TINY_SH], 2'b00};
        else
            l2_addr = {desc[AW-1:COARSE_SH], va[SECT_SH-1:SMALL_SH], 2'b00};
    end
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec
    import ptw_pkg::*;
(
    input  logic [AW-1:0]   desc,
    input  logic [AW-1:0]   va,
    input  logic            fine,
    output logic            fault,
    output logic [AW-1:0]   pa,
    output logic [AP_W-1:0] ap,
    output logic            cch,
    output logic            bfr
);
    logic [AP_W-1:0] sub_ap [SUBPAGES];

    for (genvar g = 0; g < SUBPAGES; g++) begin : g_sub
        assign sub_ap[g] = desc[SUBAP_LSB + AP_W*g +: AP_W];
    end

    always_comb begin
        fault = 1'b0;
        pa    = '0;
        ap    = '0;
        cch   = desc[C_BIT];
        bfr   = desc[B_BIT];
        unique case (desc[1:0])
            2'b01: begin
                pa = {desc[AW-1:LARGE_SH], va[LARGE_SH-1:0]};
                ap = sub_ap[va[LARGE_SH-1:LARGE_SH-2]];
            end
            2'b10: begin
                pa = {desc[AW-1:SMALL_SH], va[SMALL_SH-1:0]};
                ap = sub_ap[va[SMALL_SH-1:SMALL_SH-2]];
            end
            2'b11: begin
                if (fine) begin
                    pa = {desc[AW-1:TINY_SH], va[TINY_SH-1:0]};
                    ap = sub_ap[0];
                end else begin
                    fault = 1'b1;
                end
            end
            default: fault = 1'b1;
        endcase
        if (fault) begin
            cch = 1'b0;
            bfr = 1'b0;
        end
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_va,
    input  logic [AW-1:0]    tbl_base,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [AW-1:0]    mem_rsp_data,
    output logic             done,
    output logic             fault,
    output logic             fault_level,
    output logic [AW-1:0]    pa,
    output logic [DOM_W-1:0] domain,
    output logic [AP_W-1:0]  ap,
    output logic             cacheable,
    output logic             bufferable
);
    walk_s q_q, q_d;

    l1_kind_e         l1_kind;
    logic [AW-1:0]    l1_pa, l1_next;
    logic [DOM_W-1:0] l1_dom;
    logic [AP_W-1:0]  l1_ap;
    logic             l1_c, l1_b;
    logic             l2_fault;
    logic [AW-1:0]    l2_pa;
    logic [AP_W-1:0]  l2_ap;
    logic             l2_c, l2_b;

    ptw_l1_dec u_l1 (
        .desc(mem_rsp_data), .va(q_q.va), .kind(l1_kind), .sect_pa(l1_pa),
        .l2_addr(l1_next), .dom(l1_dom), .ap(l1_ap), .cch(l1_c), .bfr(l1_b)
    );

    ptw_l2_dec u_l2 (
        .desc(mem_rsp_data), .va(q_q.va), .fine(q_q.fine), .fault(l2_fault),
        .pa(l2_pa), .ap(l2_ap), .cch(l2_c), .bfr(l2_b)
    );

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        unique case (q_q.st)
            ST_IDLE: if (req_valid) begin
                q_d.va    = req_va;
                q_d.maddr = {tbl_base[AW-1:BASE_SH], req_va[AW-1:SECT_SH], 2'b00};
                q_d.st    = ST_L1_REQ;
            end
            ST_L1_REQ: if (mem_req_ready) q_d.st = ST_L1_WAIT;
            ST_L1_WAIT: if (mem_rsp_valid) begin
                unique case (l1_kind)
                    L1_INV: begin
                        q_d.st    = ST_IDLE;
                        q_d.done  = 1'b1;
                        q_d.fault = 1'b1;
                        q_d.flvl  = 1'b0;
                        q_d.dom   = '0;
                        q_d.pa    = '0;
                        q_d.ap    = '0;
                        q_d.cch   = 1'b0;
                        q_d.bfr   = 1'b0;
                    end
                    L1_SECT: begin
                        q_d.st    = ST_IDLE;
                        q_d.done  = 1'b1;
                        q_d.fault = 1'b0;
                        q_d.flvl  = 1'b0;
                        q_d.dom   = l1_dom;
                        q_d.pa    = l1_pa;
                        q_d.ap    = l1_ap;
                        q_d.cch   = l1_c;
                        q_d.bfr   = l1_b;
                    end
                    default: begin
                        q_d.st    = ST_L2_REQ;
                        q_d.dom   = l1_dom;
                        q_d.maddr = l1_next;
                        q_d.fine  = (l1_kind == L1_FINE);
                    end
                endcase
            end
            ST_L2_REQ: if (mem_req_ready) q_d.st = ST_L2_WAIT;
            ST_L2_WAIT: if (mem_rsp_valid) begin
                q_d.st    = ST_IDLE;
                q_d.done  = 1'b1;
                q_d.fault = l2_fault;
                q_d.flvl  = 1'b1;
                q_d.pa    = l2_pa;
                q_d.ap    = l2_ap;
                q_d.cch   = l2_c;
                q_d.bfr   = l2_b;
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign req_ready     = (q_q.st == ST_IDLE);
    assign mem_req_valid = (q_q.st == ST_L1_REQ) || (q_q.st == ST_L2_REQ);
    assign mem_req_addr  = q_q.maddr;
    assign done          = q_q.done;
    assign fault         = q_q.fault;
    assign fault_level   = q_q.flvl;
    assign pa            = q_q.pa;
    assign domain        = q_q.dom;
    assign ap            = q_q.ap;
    assign cacheable     = q_q.cch;
    assign bufferable    = q_q.bfr;

    // R11: request held stable until accepted
    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R1: descriptor reads are word aligned
    p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[1:0] == 2'b00);

    // R10: result strobe is a single cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: no memory traffic while accepting requests
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_req_valid);

    // R10: faulting result carries no translation
    p_fault_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> pa == '0 && ap == '0 && !cacheable && !bufferable);

    // R2: a first-level fault reports domain zero
    p_l1_fault_dom_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault && !fault_level |-> domain == '0);
endmodule

// File: tb/sim_ptw_walker.sv
`timescale 1ns/1ps
module sim_ptw_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        done, fault, fault_level, cacheable, bufferable;
    logic [31:0] pa;
    logic [3:0]  domain;
    logic [1:0]  ap;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    ptw_walker u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_va(req_va), .tbl_base(tbl_base), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .done(done), .fault(fault), .fault_level(fault_level), .pa(pa),
        .domain(domain), .ap(ap), .cacheable(cacheable), .bufferable(bufferable)
    );

    // memory model
    logic [31:0] m_a1, m_d1, m_a2, m_d2;
    int          lat = 0;
    bit          slow = 1'b0;
    logic        busy;
    int          lat_cnt;
    logic [31:0] pend;
    logic [1:0]  cyc;
    int          nreq = 0;
    logic [31:0] log_a [0:15];

    assign mem_req_ready = !busy && (!slow || cyc == 2'd3);

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy          <= 1'b0;
            mem_rsp_valid <= 1'b0;
            mem_rsp_data  <= '0;
            cyc           <= '0;
            lat_cnt       <= 0;
            pend          <= '0;
        end else begin
            cyc           <= cyc + 2'd1;
            mem_rsp_valid <= 1'b0;
            if (!busy && mem_req_valid && mem_req_ready) begin
                busy            <= 1'b1;
                lat_cnt         <= lat;
                pend            <= mem_req_addr;
                log_a[nreq % 16] <= mem_req_addr;
                nreq            <= nreq + 1;
            end else if (busy) begin
                if (lat_cnt == 0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data  <= (pend == m_a1) ? m_d1 :
                                     (pend == m_a2) ? m_d2 : 32'hDEAD_BEEF;
                    busy          <= 1'b0;
                end else begin
                    lat_cnt <= lat_cnt - 1;
                end
            end
        end
    end

    // captured results
    logic        r_got, r_fault, r_lvl, r_c, r_b;
    logic [31:0] r_pa, r_a1, r_a2;
    logic [3:0]  r_dom;
    logic [1:0]  r_ap;
    int          r_nreq;

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic walk(input logic [31:0] va, input logic [31:0] base,
                        input logic [31:0] d1, input logic [31:0] d2,
                        input int lt, input bit sl);
        int n0;
        m_d1 = d1;
        m_d2 = d2;
        m_a1 = {base[31:14], va[31:20], 2'b00};
        m_a2 = (d1[1:0] == 2'b11) ? {d1[31:12], va[19:10], 2'b00}
                                  : {d1[31:10], va[19:12], 2'b00};
        lat  = lt;
        slow = sl;
        n0   = nreq;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = va;
        tbl_base  = base;
        @(negedge clk);
        req_valid = 1'b0;
        r_got = 1'b0;
        for (int i = 0; i < 400 && !r_got; i++) begin
            @(negedge clk);
            if (done) begin
                r_got   = 1'b1;
                r_fault = fault;
                r_lvl   = fault_level;
                r_pa    = pa;
                r_dom   = domain;
                r_ap    = ap;
                r_c     = cacheable;
                r_b     = bufferable;
                chk("R10 ready at done", {31'd0, req_ready}, 32'd1);
            end
        end
        chk("R11 walk completes", {31'd0, r_got}, 32'd1);
        @(negedge clk);
        chk("R10 done single cycle", {31'd0, done}, 32'd0);
        r_nreq = nreq - n0;
        r_a1   = log_a[n0 % 16];
        r_a2   = log_a[(n0 + 1) % 16];
    endtask

    task automatic t_reset_state;
        chk("R10 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R10 reset done", {31'd0, done}, 32'd0);
        chk("R10 reset no read", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_l1_fault;
        logic [31:0] va = 32'h7654_3210;
        logic [31:0] bs = 32'hA5A5_C123;
        walk(va, bs, 32'hFFFF_FFFC, 32'h0, 1, 1'b0);
        chk("R1 first read addr", r_a1, {bs[31:14], va[31:20], 2'b00});
        chk("R2 one read", r_nreq, 32'd1);
        chk("R2 fault", {31'd0, r_fault}, 32'd1);
        chk("R2 level", {31'd0, r_lvl}, 32'd0);
        chk("R2 domain", {28'd0, r_dom}, 32'd0);
        chk("R10 fault pa", r_pa, 32'd0);
    endtask

    task automatic t_section;
        logic [31:0] va = 32'h1234_5678;
        logic [31:0] d  = 32'hABC0_0000 | (32'd2 << 10) | (32'hD << 5) | 32'h8 | 32'h2;
        walk(va, 32'h0004_0000, d, 32'h0, 3, 1'b1);
        chk("R3 one read", r_nreq, 32'd1);
        chk("R3 fault", {31'd0, r_fault}, 32'd0);
        chk("R3 pa", r_pa, {12'hABC, va[19:0]});
        chk("R3 ap", {30'd0, r_ap}, 32'd2);
        chk("R3 domain", {28'd0, r_dom}, 32'hD);
        chk("R3 cacheable", {31'd0, r_c}, 32'd1);
        chk("R3 bufferable", {31'd0, r_b}, 32'd0);
    endtask

    // subpage fields k0..k3 = 0,1,2,3
    localparam logic [31:0] SUBS = (32'd0 << 4) | (32'd1 << 6) | (32'd2 << 8) | (32'd3 << 10);

    task automatic t_coarse_small;
        logic [31:0] va = 32'h0AB5_8ABC;  // va[11:10] = 2
        logic [31:0] d1 = 32'h1357_9C00 | (32'h5 << 5) | 32'h1;
        logic [31:0] d2 = 32'hFEDC_B000 | SUBS | 32'h4 | 32'h2;
        walk(va, 32'h0010_0000, d1, d2, 0, 1'b0);
        chk("R4 coarse addr", r_a2, {d1[31:10], va[19:12], 2'b00});
        chk("R4 two reads", r_nreq, 32'd2);
        chk("R4 domain", {28'd0, r_dom}, 32'h5);
        chk("R7 pa", r_pa, {20'hFEDCB, va[11:0]});
        chk("R7 ap", {30'd0, r_ap}, 32'd2);
        chk("R7 bufferable", {31'd0, r_b}, 32'd1);
        chk("R7 cacheable", {31'd0, r_c}, 32'd0);
    endtask

    task automatic t_coarse_large;
        logic [31:0] va = 32'h0015_4321;  // va[15:14] = 1
        logic [31:0] d1 = 32'h0002_0400 | (32'h9 << 5) | 32'h1;
        logic [31:0] d2 = 32'h8765_0000 | SUBS | 32'h8 | 32'h1;
        walk(va, 32'h0000_8000, d1, d2, 5, 1'b1);
        chk("R6 pa", r_pa, {16'h8765, va[15:0]});
        chk("R6 ap", {30'd0, r_ap}, 32'd1);
        chk("R6 cacheable", {31'd0, r_c}, 32'd1);
        chk("R6 fault", {31'd0, r_fault}, 32'd0);
    endtask

    task automatic t_coarse_type3;
        logic [31:0] va = 32'h00FF_F3FF;
        logic [31:0] d1 = 32'h0030_0000 | (32'h3 << 5) | 32'h1;
        walk(va, 32'h0000_0000, d1, 32'hFFFF_FFFF, 2, 1'b0);
        chk("R8 coarse type3 fault", {31'd0, r_fault}, 32'd1);
        chk("R8 level", {31'd0, r_lvl}, 32'd1);
        chk("R8 domain kept", {28'd0, r_dom}, 32'h3);
        chk("R10 fault ap", {30'd0, r_ap}, 32'd0);
    endtask

    task automatic t_fine_tiny;
        logic [31:0] va = 32'hC03A_B5A5;
        logic [31:0] d1 = 32'h4444_5000 | (32'hE << 5) | 32'h3;
        logic [31:0] d2 = 32'h2468_AC00 | (32'h3 << 4) | (32'h1 << 6) | 32'h4 | 32'h3;
        walk(va, 32'hFFFF_C000, d1, d2, 1, 1'b1);
        chk("R4 fine addr", r_a2, {d1[31:12], va[19:10], 2'b00});
        chk("R8 tiny pa", r_pa, {22'h091A2B, va[9:0]});
        chk("R8 tiny ap", {30'd0, r_ap}, 32'd3);
        chk("R8 domain", {28'd0, r_dom}, 32'hE);
        chk("R8 bufferable", {31'd0, r_b}, 32'd1);
    endtask

    task automatic t_fine_small_large;
        logic [31:0] va = 32'h0100_0C00;  // va[11:10] = 3
        logic [31:0] d1 = 32'h0000_7000 | 32'h3;
        logic [31:0] d2 = 32'h1111_1000 | SUBS | 32'h2;
        walk(va, 32'h0000_4000, d1, d2, 0, 1'b0);
        chk("R9 fine small pa", r_pa, {20'h11111, va[11:0]});
        chk("R9 fine small ap", {30'd0, r_ap}, 32'd3);
        va = 32'h0200_8000;               // va[15:14] = 2
        d2 = 32'h9999_0000 | SUBS | 32'h1;
        walk(va, 32'h0000_4000, d1, d2, 4, 1'b1);
        chk("R9 fine large pa", r_pa, {16'h9999, va[15:0]});
        chk("R9 fine large ap", {30'd0, r_ap}, 32'd2);
    endtask

    task automatic t_l2_invalid;
        logic [31:0] va = 32'h0A0A_0A0A;
        logic [31:0] d1 = 32'h0055_5000 | (32'h7 << 5) | 32'h3;
        walk(va, 32'h0000_0000, d1, 32'hFFFF_FFFC, 6, 1'b0);
        chk("R5 fault", {31'd0, r_fault}, 32'd1);
        chk("R5 level", {31'd0, r_lvl}, 32'd1);
        chk("R5 domain", {28'd0, r_dom}, 32'h7);
        chk("R10 fault cacheable", {31'd0, r_c}, 32'd0);
    endtask

    task automatic t_reset_midwalk;
        int seen = 0;
        m_a1 = 32'h0;
        m_d1 = 32'h0000_0002;
        lat  = 40;
        slow = 1'b0;
        @(negedge clk);
        req_valid = 1'b1;
        req_va    = 32'h0000_0000;
        tbl_base  = 32'h0;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (done) seen++;
        end
        chk("R12 no done after reset", seen, 32'd0);
        chk("R12 idle after reset", {31'd0, req_ready}, 32'd1);
        chk("R12 no read after reset", {31'd0, mem_req_valid}, 32'd0);
        walk(32'h3210_0123, 32'h0, 32'h5550_0000 | 32'h2, 32'h0, 0, 1'b0);
        chk("R12 walk after reset", r_pa, 32'h5550_0123);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_l1_fault();
        t_section();
        t_coarse_small();
        t_coarse_large();
        t_coarse_type3();
        t_fine_tiny();
        t_fine_small_large();
        t_l2_invalid();
        t_reset_midwalk();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule